// File: doc/BRIEF.md
# Pipelined Bus Memory Slave with Inserted Wait States

This block is a single-master AHB-Lite slave that fronts a small word-organised memory. A transfer's address and control are sampled in the cycle the master presents them (the address phase). The data moves in the cycle or cycles that follow (the data phase), while the master is already presenting the next transfer's address. The slave always stretches each data phase by a fixed number of wait cycles, set by a parameter, by holding its ready output low. That stretch also holds the overlapping address phase of the next transfer, because the master sees the bus as not ready.

Writes may be byte, halfword or word sized, and land in little-endian byte lanes picked from the low address bits. Reads always return the full addressed word. IDLE and BUSY cycles, unselected cycles and cycles in which the bus is not ready start nothing. The protection, lock and burst inputs are accepted and have no effect. The response is always OKAY.

Top module: `ahbw_mem_slave`

## Requirements
- R1: Out of reset, HREADYOUT is 1 and HRESP is 0.
- R2: A cycle with HTRANS IDLE (2'b00) or BUSY (2'b01), or with HSEL low, starts no transfer: HREADYOUT stays 1 in the next cycle and no memory word changes.
- R3: Every accepted transfer has a data phase in which HREADYOUT is 0 for exactly WAIT_STATES cycles (default 2) and then 1 for one cycle.
- R4: HREADYOUT is 1 whenever no data phase is in progress.
- R5: A write commits HWDATA, sampled at the clock edge that ends its data phase, to little-endian lanes. HSIZE 3'b000 writes lane HADDR[1:0]. HSIZE 3'b001 writes lanes 1:0 when HADDR[1] is 0 and lanes 3:2 otherwise. HSIZE 3'b010 writes all four lanes. Other lanes keep their value.
- R6: A read drives on HRDATA the full 32-bit word indexed by HADDR[IDX_W+1:2] (bits [7:2] at the default depth of 64), valid in the last cycle of its data phase. Upper address bits are ignored.
- R7: HRESP is 0 in every cycle.
- R8: Transfers pipeline back to back. The next address is taken at the same edge that ends the previous data phase, and a read directly after a write to the same word returns the merged new data.
- R9: An address phase presented while the HREADY input is 0 is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| HCLK | input | 1 | Clock, rising edge |
| HRESETn | input | 1 | Asynchronous active-low reset |
| HSEL | input | 1 | Slave select |
| HADDR | input | ADDR_W | Byte address |
| HTRANS | input | 2 | Transfer type |
| HWRITE | input | 1 | 1 = write, 0 = read |
| HSIZE | input | 3 | Transfer size |
| HBURST | input | 3 | Burst type (unused) |
| HPROT | input | 4 | Protection info (unused) |
| HMASTLOCK | input | 1 | Locked sequence (unused) |
| HWDATA | input | 32 | Write data |
| HREADY | input | 1 | Bus-wide ready |
| HRDATA | output | 32 | Read data |
| HREADYOUT | output | 1 | Slave ready, low during wait cycles |
| HRESP | output | 1 | Response, always OKAY |

## Verification
The hardest situation to reach is a new address phase held through the wait cycles of a previous data phase. This happens only when the master keeps issuing transfers with no gap. The bench therefore drives batches of operations back to back: each next address stays on the bus while it counts the low ready cycles of the current transfer. The batches mix random sizes, offsets, upper address bits, IDLE/BUSY cycles and deselected cycles, and are checked against a bench-side byte-lane model. Directed cases add a read straight after a partial write to the same word, and an address phase offered while the bus ready input is forced low.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam int LANES = 4;

  // Little-endian lane enables for a write of the given size at byte offset off.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] off, input logic [2:0] size);
    logic [LANES-1:0] m;
    case (size)
      3'd0:    m = 4'b0001 << off;
      3'd1:    m = off[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ahbw_addr_phase.sv
module ahbw_addr_phase #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [1:0]        trans,
  input  logic              bus_ready,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [2:0]        size,
  output logic              accept,
  output logic              dp_valid,
  output logic              dp_write,
  output logic [IDX_W-1:0]  dp_idx,
  output logic [3:0]        dp_lanes
);
  import ahbw_pkg::*;

  logic             valid_n;
  logic             write_q;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       lanes_q;

  // NONSEQ and SEQ both have bit 1 set; IDLE and BUSY do not.
  assign accept = sel && bus_ready && trans[1];

  always_comb begin
    valid_n = dp_valid;
    if (bus_ready) valid_n = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dp_valid <= 1'b0;
    else        dp_valid <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      write_q <= write;
      idx_q   <= addr[IDX_W+1:2];
      lanes_q <= lane_mask(addr[1:0], size);
    end
  end

  assign dp_write = write_q;
  assign dp_idx   = idx_q;
  assign dp_lanes = lanes_q;

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr[ADDR_W-1:IDX_W+2];

endmodule

// File: rtl/ahbw_wait_ctr.sv
module ahbw_wait_ctr #(
  parameter int WAIT_STATES = 2,
  parameter int CNT_W       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)              cnt_n = CNT_W'(WAIT_STATES);
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign ready = (cnt_q == '0);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WAIT_STATES));

endmodule

// File: rtl/ahbw_mem.sv
module ahbw_mem #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       lanes,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lanes[g]) bank[idx] <= wdata[8*g +: 8];
    end
    assign rdata[8*g +: 8] = bank[idx];
  end

  // R5
  lanes_nonzero_chk: assert property (@(posedge clk) we |-> (lanes != 4'b0000));

endmodule

// File: rtl/ahbw_mem_slave.sv
module ahbw_mem_slave #(
  parameter int ADDR_W      = 32,
  parameter int DEPTH       = 64,
  parameter int WAIT_STATES = 2
) (
  input  logic              HCLK,
  input  logic              HRESETn,
  input  logic              HSEL,
  input  logic [ADDR_W-1:0] HADDR,
  input  logic [1:0]        HTRANS,
  input  logic              HWRITE,
  input  logic [2:0]        HSIZE,
  input  logic [2:0]        HBURST,
  input  logic [3:0]        HPROT,
  input  logic              HMASTLOCK,
  input  logic [31:0]       HWDATA,
  input  logic              HREADY,
  output logic [31:0]       HRDATA,
  output logic              HREADYOUT,
  output logic              HRESP
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);

  logic             accept, dp_valid, dp_write;
  logic [IDX_W-1:0] dp_idx;
  logic [3:0]       dp_lanes;
  logic [31:0]      mem_rd;
  logic             mem_we;

  ahbw_addr_phase #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_aph (
    .clk(HCLK), .rst_n(HRESETn), .sel(HSEL), .trans(HTRANS), .bus_ready(HREADY),
    .addr(HADDR), .write(HWRITE), .size(HSIZE), .accept(accept),
    .dp_valid(dp_valid), .dp_write(dp_write), .dp_idx(dp_idx), .dp_lanes(dp_lanes)
  );

  ahbw_wait_ctr #(.WAIT_STATES(WAIT_STATES), .CNT_W(CNT_W)) u_wait (
    .clk(HCLK), .rst_n(HRESETn), .load(accept), .ready(HREADYOUT)
  );

  assign mem_we = dp_valid && dp_write && HREADY;

  ahbw_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk(HCLK), .we(mem_we), .idx(dp_idx), .lanes(dp_lanes), .wdata(HWDATA), .rdata(mem_rd)
  );

  assign HRDATA = (dp_valid && !dp_write) ? mem_rd : 32'h0;
  assign HRESP  = 1'b0;

  logic unused_ctl;
  assign unused_ctl = ^{HBURST, HPROT, HMASTLOCK};

  // R2
  idle_no_wait_chk: assert property (@(posedge HCLK) disable iff (!HRESETn)
    (HSEL && HREADY && !HTRANS[1]) |=> HREADYOUT);

  // R3
  accept_wait_chk: assert property (@(posedge HCLK) disable iff (!HRESETn)
    accept |=> (HREADYOUT == (WAIT_STATES == 0)));

  // R4
  idle_ready_chk: assert property (@(posedge HCLK) disable iff (!HRESETn)
    !HREADYOUT |-> dp_valid);

  // R9
  stall_no_accept_chk: assert property (@(posedge HCLK) disable iff (!HRESETn)
    (!HREADY && !dp_valid) |=> !dp_valid);

endmodule

// File: tb/tb_ahbw_mem_slave.sv
module tb_ahbw_mem_slave;
  localparam int NW = 64;
  localparam int WS = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, hsel, hwrite, hmastlock, hready_en, hready, hreadyout, hresp;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;
  logic [3:0]  hprot;

  assign hready = hreadyout & hready_en;

  ahbw_mem_slave #(.ADDR_W(32), .DEPTH(NW), .WAIT_STATES(WS)) dut (
    .HCLK(clk), .HRESETn(rst_n), .HSEL(hsel), .HADDR(haddr), .HTRANS(htrans),
    .HWRITE(hwrite), .HSIZE(hsize), .HBURST(hburst), .HPROT(hprot),
    .HMASTLOCK(hmastlock), .HWDATA(hwdata), .HREADY(hready), .HRDATA(hrdata),
    .HREADYOUT(hreadyout), .HRESP(hresp)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] model [NW];

  bit          op_w   [NW];
  bit          op_sel [NW];
  logic [31:0] op_a   [NW];
  logic [31:0] op_d   [NW];
  logic [2:0]  op_sz  [NW];
  logic [1:0]  op_tr  [NW];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lanes(input logic [1:0] off, input logic [2:0] sz);
    if (sz == 3'd0) return 4'b0001 << off;
    if (sz == 3'd1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] ln);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (ln[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic drive_op(input int i);
    hsel = op_sel[i]; haddr = op_a[i]; htrans = op_tr[i]; hwrite = op_w[i]; hsize = op_sz[i];
    hburst = 3'($urandom); hprot = 4'($urandom); hmastlock = 1'($urandom);
  endtask

  task automatic drive_idle();
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hsize = 3'd2; haddr = 32'h0;
  endtask

  function automatic bit taken(input int i);
    return op_sel[i] && op_tr[i][1];
  endfunction

  task automatic set_op(input int i, input bit w, input logic [31:0] a, input logic [2:0] sz,
                        input logic [31:0] d, input logic [1:0] tr, input bit s);
    op_w[i] = w; op_a[i] = a; op_sz[i] = sz; op_d[i] = d; op_tr[i] = tr; op_sel[i] = s;
  endtask

  // Back-to-back driver: op i's address phase overlaps op i-1's data phase.
  task automatic run_batch(input int n);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i < n) drive_op(i); else drive_idle();
      if (i > 0) begin
        int p = i - 1;
        if (taken(p)) begin
          int waits = 0;
          int ix = int'(op_a[p][7:2]);
          if (op_w[p]) hwdata = op_d[p]; else hwdata = $urandom;
          while (!hreadyout && waits < 10) begin
            chk(hresp == 1'b0, "R7", 32'(hresp), 32'h0);
            waits++;
            @(negedge clk);
          end
          chk(waits == WS, "R3 wait count", 32'(waits), 32'(WS));
          if (op_w[p]) model[ix] = merge(model[ix], op_d[p], exp_lanes(op_a[p][1:0], op_sz[p]));
          else chk(hrdata == model[ix], "R6 R8 read data", hrdata, model[ix]);
        end else begin
          // R2 / R4: nothing started, slave stays ready
          chk(hreadyout == 1'b1, "R2 R4 ignored", 32'(hreadyout), 32'h1);
        end
      end
      @(posedge clk);
    end
  endtask

  task automatic readback_all();
    for (int k = 0; k < NW; k++)
      set_op(k, 1'b0, {24'($urandom), 6'(k), 2'b00}, 3'd2, 32'h0, (k == 0) ? 2'b10 : 2'b11, 1'b1);
    run_batch(NW);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5171));
    rst_n = 1'b0; hready_en = 1'b1; hwdata = '0; hburst = '0; hprot = '0; hmastlock = 1'b0;
    drive_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(hreadyout == 1'b1, "R1 ready", 32'(hreadyout), 32'h1);
    chk(hresp == 1'b0, "R1 resp", 32'(hresp), 32'h0);
    rst_n = 1'b1;

    // Initialise every word with a word write (R5 full word)
    for (int k = 0; k < NW; k++)
      set_op(k, 1'b1, {24'h0, 6'(k), 2'b00}, 3'd2, $urandom, 2'b10, 1'b1);
    run_batch(NW);
    readback_all();

    // Directed R8: partial writes then immediate read of the same word
    set_op(0, 1'b1, 32'h0000_0010, 3'd2, 32'hA1B2C3D4, 2'b10, 1'b1);
    set_op(1, 1'b1, 32'h0000_0013, 3'd0, 32'h5E000000, 2'b11, 1'b1);
    set_op(2, 1'b0, 32'h0000_0010, 3'd2, 32'h0, 2'b11, 1'b1);
    set_op(3, 1'b1, 32'hFF00_0012, 3'd1, 32'h77660000, 2'b10, 1'b1);
    set_op(4, 1'b1, 32'h0000_0011, 3'd0, 32'h00009900, 2'b11, 1'b1);
    set_op(5, 1'b0, 32'h0000_0010, 3'd0, 32'h0, 2'b11, 1'b1);
    run_batch(6);
    chk(model[4] == 32'h7766_99D4, "R5 lane merge model", model[4], 32'h7766_99D4);

    // Directed R2: IDLE, BUSY and deselected writes leave memory alone
    set_op(0, 1'b1, 32'h0000_0020, 3'd2, 32'hDEADBEEF, 2'b00, 1'b1);
    set_op(1, 1'b1, 32'h0000_0020, 3'd2, 32'hDEADBEEF, 2'b01, 1'b1);
    set_op(2, 1'b1, 32'h0000_0020, 3'd2, 32'hDEADBEEF, 2'b10, 1'b0);
    set_op(3, 1'b0, 32'h0000_0020, 3'd2, 32'h0, 2'b10, 1'b1);
    run_batch(4);

    // Directed R9: address phase while bus ready is held low by another slave
    @(negedge clk);
    hready_en = 1'b0;
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2; haddr = 32'h0000_0024;
    hwdata = 32'h1234_5678;
    @(posedge clk);
    @(negedge clk);
    drive_idle();
    hready_en = 1'b1;
    chk(hreadyout == 1'b1, "R9 not accepted", 32'(hreadyout), 32'h1);
    set_op(0, 1'b0, 32'h0000_0024, 3'd2, 32'h0, 2'b10, 1'b1);
    run_batch(1);

    // Random back-to-back traffic
    for (int b = 0; b < 20; b++) begin
      for (int k = 0; k < 16; k++) begin
        logic [2:0]  sz = 3'($urandom % 3);
        logic [7:0]  lo = 8'($urandom);
        logic [31:0] a;
        if (sz == 3'd1) lo[0] = 1'b0;
        if (sz == 3'd2) lo[1:0] = 2'b00;
        a = {24'($urandom), lo};
        set_op(k, 1'($urandom), a, sz, $urandom, 2'($urandom), ($urandom % 8) != 0);
      end
      run_batch(16);
    end

    // Final sweep confirms R5 lanes and that R2/R9 stimuli wrote nothing
    readback_all();
    @(negedge clk);
    chk(hreadyout == 1'b1, "R4 idle end", 32'(hreadyout), 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule